// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block connects a synchronous single-request port to an external asynchronous static RAM of one million 32-bit words. A request carries a word address, write data, a read/write flag and one strobe bit per byte lane. It is accepted on a clock where both valid and ready are high. The controller then sequences the memory's address, per-lane chip selects, shared write enable and shared output enable. Every phase length is a whole number of system clocks, found by rounding the memory's nanosecond limit up to the clock period. The same RTL therefore serves any speed grade, given the right timing parameters.

Each access runs through four phases: idle, address setup, strobe, and hold/turnaround. The memory stores only the byte lanes whose strobe bit is set. A read enables all four lanes and captures the full word on the closing edge of the access wait. The captured word comes back with a single-cycle valid pulse. The data bus is split into an output word, an input word and one drive-enable, which the pad ring combines into the bidirectional bus.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and at once while rst_ni is low, req_ready_o is 1, all mem_cs_no bits are 1, mem_we_no and mem_oe_no are 1, mem_dq_oe_o is 0 and rd_valid_o is 0.
- R2: A request is accepted on a rising edge where req_valid_i and req_ready_o are both 1. req_ready_o is then 0 for setup + strobe + hold cycles, which is 1+4+1 = 6 for a write and 1+3+2 = 6 for a read with the default timing (4 ns clock).
- R3: mem_addr_o takes the request address at acceptance and changes only while every chip select is high. It is valid for at least one setup cycle before any strobe goes low.
- R4: During a write, mem_we_no is low for ceil(15 ns / clock) = 4 cycles and mem_oe_no stays high. mem_cs_no[i] is low exactly when strobe bit i is set; bit i selects data bits 8i+7..8i.
- R5: For a write, mem_dq_oe_o is 1 with mem_dq_o equal to the write data through the setup and strobe phases (5 cycles by default), and 0 from the hold phase on.
- R6: A write whose strobes are all zero keeps the normal write timing but asserts no chip select, so memory contents are unchanged.
- R7: During a read, all chip selects and mem_oe_no are low and mem_we_no is high for ceil(12 ns / clock) = 3 cycles. mem_dq_oe_o stays 0 for the whole read.
- R8: rd_data_o takes mem_dq_i at the edge that closes the read strobe, and rd_valid_o is high for exactly the next cycle. Writes raise no valid pulse and leave rd_data_o unchanged.
- R9: After a read, every strobe stays high for ceil(7 ns / clock) = 2 turnaround cycles before ready returns. mem_dq_oe_o is never 1 while mem_oe_no is low, nor within that many cycles after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, can accept |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_addr_i | input | ADDR_W (20) | Word address |
| req_wdata_i | input | DATA_W (32) | Write data |
| req_strb_i | input | LANES (4) | Byte-lane write strobes |
| rd_valid_o | output | 1 | One-cycle read data valid |
| rd_data_o | output | DATA_W (32) | Captured read word |
| mem_addr_o | output | ADDR_W (20) | Memory address bus |
| mem_cs_no | output | LANES (4) | Per-lane chip selects, active low |
| mem_we_no | output | 1 | Shared write enable, active low |
| mem_oe_no | output | 1 | Shared output enable, active low |
| mem_dq_o | output | DATA_W (32) | Data to drive onto the bus |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | DATA_W (32) | Data sampled from the bus |

## Verification
The assertions assume the clock period parameter matches the real clock. They also assume the external memory drives the bus only while output enable is low and write enable is high, and that it returns valid data within the access wait. Request fields are taken for granted only on the accepting edge, since the controller latches them there. The bench keeps to these assumptions in three ways. Its memory model answers combinationally and only in the read condition. It presents each request for exactly one accepted edge. It always waits for ready before the next request, including the read-to-write turnaround.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  function automatic int unsigned ceil_div(input int unsigned n, input int unsigned d);
    return (n + d - 1) / d;
  endfunction

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  strb_i,
  output logic              rd_q_o,
  output logic              rd_nxt_o,
  output logic [LANES-1:0]  strb_nxt_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] wdata_q_o
);
  logic [LANES-1:0] strb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q_o    <= 1'b1;
      strb_q    <= '0;
      addr_q_o  <= '0;
      wdata_q_o <= '0;
    end else if (start_i) begin
      rd_q_o    <= rd_i;
      strb_q    <= strb_i;
      addr_q_o  <= addr_i;
      wdata_q_o <= wdata_i;
    end
  end

  // next-cycle view so registered strobes line up with the phase register
  assign rd_nxt_o   = start_i ? rd_i   : rd_q_o;
  assign strb_nxt_o = start_i ? strb_i : strb_q;
endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_lane_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned WR_CYC    = 4,
  parameter int unsigned RD_CYC    = 3,
  parameter int unsigned WR_HOLD   = 1,
  parameter int unsigned RD_HOLD   = 2,
  parameter int unsigned CNT_W     = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   rd_i,
  output phase_e phase_q_o,
  output phase_e phase_d_o,
  output logic   last_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_SETUP;
        cnt_d   = CNT_W'(SETUP_CYC - 1);
      end
      PH_SETUP: if (cnt_q == '0) begin
        phase_d = PH_STROBE;
        cnt_d   = rd_i ? CNT_W'(RD_CYC - 1) : CNT_W'(WR_CYC - 1);
      end else cnt_d = cnt_q - 1'b1;
      PH_STROBE: if (cnt_q == '0) begin
        phase_d = PH_HOLD;
        cnt_d   = rd_i ? CNT_W'(RD_HOLD - 1) : CNT_W'(WR_HOLD - 1);
      end else cnt_d = cnt_q - 1'b1;
      PH_HOLD: if (cnt_q == '0) phase_d = PH_IDLE;
               else cnt_d = cnt_q - 1'b1;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_q_o = phase_q;
  assign phase_d_o = phase_d;
  assign last_o    = (cnt_q == '0);

  assert_idle_waits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !start_i) |=> phase_q == PH_IDLE);
  assert_hold_ends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD && cnt_q == '0) |=> phase_q == PH_IDLE);
  assert_setup_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STROBE) |-> $past(phase_q) inside {PH_SETUP, PH_STROBE});
endmodule

// File: rtl/sram_lane_drv.sv
module sram_lane_drv
  import sram_lane_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter int unsigned WR_CYC  = 4,
  parameter int unsigned REL_CYC = 2,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_d_i,
  input  logic             rd_nxt_i,
  input  logic [LANES-1:0] strb_nxt_i,
  output logic [LANES-1:0] cs_no,
  output logic             we_no,
  output logic             oe_no,
  output logic             dq_oe_o
);
  logic strobe_d;
  assign strobe_d = (phase_d_i == PH_STROBE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cs_no[g] <= 1'b1;
      else         cs_no[g] <= !(strobe_d && (rd_nxt_i || strb_nxt_i[g]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_no   <= 1'b1;
      oe_no   <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      we_no   <= !(strobe_d && !rd_nxt_i);
      oe_no   <= !(strobe_d && rd_nxt_i);
      dq_oe_o <= !rd_nxt_i && (phase_d_i == PH_SETUP || phase_d_i == PH_STROBE);
    end
  end

  // checker counters: write pulse length, cycles since output enable released
  logic [CNT_W-1:0] we_lo_q, oe_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_q <= '0;
      oe_hi_q <= CNT_W'(REL_CYC);
    end else begin
      we_lo_q <= !we_no ? ((we_lo_q == '1) ? we_lo_q : we_lo_q + 1'b1) : '0;
      oe_hi_q <= !oe_no ? '0
               : ((oe_hi_q >= CNT_W'(REL_CYC)) ? oe_hi_q : oe_hi_q + 1'b1);
    end
  end

  assert_we_excl_oe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> oe_no);
  assert_wpulse_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> we_lo_q >= CNT_W'(WR_CYC));
  assert_drive_after_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (oe_no && oe_hi_q >= CNT_W'(REL_CYC)));
  assert_read_all_lanes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> (cs_no == '0 && !dq_oe_o));
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture
  import sram_lane_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_q_i,
  input  logic              last_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic cap;
  assign cap = (phase_q_i == PH_STROBE) && last_i && rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= cap;
      if (cap) data_o <= dq_i;
    end
  end

  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_data_steady_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cap) |-> $stable(data_o));
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W        = 20,
  parameter int unsigned LANES         = 4,
  parameter int unsigned LANE_W        = 8,
  parameter int unsigned CLK_PS        = 4000,
  parameter int unsigned T_ASETUP_PS   = 0,
  parameter int unsigned T_ACCESS_PS   = 12000,
  parameter int unsigned T_WPULSE_PS   = 15000,
  parameter int unsigned T_WRECOV_PS   = 0,
  parameter int unsigned T_RELEASE_PS  = 7000,
  localparam int unsigned DATA_W       = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_rd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_strb_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_cs_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned SETUP_CYC = at_least_one(ceil_div(T_ASETUP_PS, CLK_PS));
  localparam int unsigned WR_CYC    = at_least_one(ceil_div(T_WPULSE_PS, CLK_PS));
  localparam int unsigned RD_CYC    = at_least_one(ceil_div(T_ACCESS_PS, CLK_PS));
  localparam int unsigned WR_HOLD   = at_least_one(ceil_div(T_WRECOV_PS, CLK_PS));
  localparam int unsigned RD_HOLD   = at_least_one(ceil_div(T_RELEASE_PS, CLK_PS));
  localparam int unsigned MAX_CYC   = max2(max2(SETUP_CYC, WR_CYC),
                                           max2(max2(RD_CYC, WR_HOLD), RD_HOLD));
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 2);

  phase_e           phase_q, phase_d;
  logic             last, start, rd_q, rd_nxt;
  logic [LANES-1:0] strb_nxt;

  assign req_ready_o = (phase_q == PH_IDLE);
  assign start       = req_valid_i && req_ready_o;

  sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_latch (
    .clk_i, .rst_ni, .start_i(start), .rd_i(req_rd_i), .addr_i(req_addr_i),
    .wdata_i(req_wdata_i), .strb_i(req_strb_i), .rd_q_o(rd_q), .rd_nxt_o(rd_nxt),
    .strb_nxt_o(strb_nxt), .addr_q_o(mem_addr_o), .wdata_q_o(mem_dq_o)
  );

  sram_phase_fsm #(
    .SETUP_CYC(SETUP_CYC), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC),
    .WR_HOLD(WR_HOLD), .RD_HOLD(RD_HOLD), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i(start), .rd_i(rd_q),
    .phase_q_o(phase_q), .phase_d_o(phase_d), .last_o(last)
  );

  sram_lane_drv #(.LANES(LANES), .WR_CYC(WR_CYC), .REL_CYC(RD_HOLD), .CNT_W(CNT_W)) u_drv (
    .clk_i, .rst_ni, .phase_d_i(phase_d), .rd_nxt_i(rd_nxt), .strb_nxt_i(strb_nxt),
    .cs_no(mem_cs_no), .we_no(mem_we_no), .oe_no(mem_oe_no), .dq_oe_o(mem_dq_oe_o)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .phase_q_i(phase_q), .last_i(last), .rd_i(rd_q),
    .dq_i(mem_dq_i), .valid_o(rd_valid_o), .data_o(rd_data_o)
  );

  assert_addr_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> ($past(&mem_cs_no) && (&mem_cs_no) && mem_we_no));
  assert_busy_no_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> $stable(mem_addr_o));
endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_rd = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_strb = '0;
  logic        ready, rd_valid, we_n, oe_n, dq_oe;
  logic [31:0] rd_data, dq_o, dq_i;
  logic [19:0] maddr;
  logic [3:0]  cs_n;

  always #2 clk = ~clk;

  sram_lane_ctrl u_dut (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_ready_o(ready), .req_rd_i(req_rd),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_strb_i(req_strb),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .mem_addr_o(maddr), .mem_cs_no(cs_n),
    .mem_we_no(we_n), .mem_oe_no(oe_n), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // memory model: 16 words, drives only in the read condition
  logic [31:0] mem [16];
  always_comb begin
    dq_i = 32'h5A5A_5A5A;
    if (!oe_n && we_n)
      for (int l = 0; l < 4; l++)
        if (!cs_n[l]) dq_i[8*l +: 8] = mem[maddr[3:0]][8*l +: 8];
  end

  int total = 0, bad = 0;
  int m_we, m_oe, m_vld, m_drv, m_clash, m_addr_err, m_data_err;
  logic [3:0]  m_cs;
  logic [19:0] cur_addr;
  logic [31:0] cur_wdata;

  always @(negedge clk) if (rst_ni) begin
    if (!we_n) m_we++;
    if (!oe_n) m_oe++;
    if (rd_valid) m_vld++;
    if (dq_oe) m_drv++;
    if (dq_oe && !oe_n) m_clash++;
    m_cs |= ~cs_n;
    if (cs_n != 4'hF && maddr != cur_addr) m_addr_err++;
    if (dq_oe && dq_o != cur_wdata) m_data_err++;
    if (!we_n)
      for (int l = 0; l < 4; l++)
        if (!cs_n[l] && dq_oe) mem[maddr[3:0]][8*l +: 8] <= dq_o[8*l +: 8];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic rd, input logic [3:0] st, input logic [3:0] a,
                         input logic [31:0] d, output int busy);
    @(negedge clk);
    req_valid = 1'b1; req_rd = rd; req_strb = st; req_addr = {16'h0, a}; req_wdata = d;
    @(posedge clk);
    #1;
    m_we = 0; m_oe = 0; m_vld = 0; m_drv = 0; m_clash = 0; m_addr_err = 0; m_data_err = 0;
    m_cs = '0; cur_addr = {16'h0, a}; cur_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~d; req_addr = 20'hFFFFF;
    busy = 0;
    while (!ready && busy < 100) begin busy++; @(negedge clk); end
  endtask

  // {rd, strb, addr, data}; for reads the data field is the expected word
  localparam logic [40:0] VEC [12] = '{
    {1'b0, 4'hF, 4'h0, 32'h1122_3344},
    {1'b0, 4'hF, 4'h1, 32'hA5A5_A5A5},
    {1'b0, 4'h1, 4'h2, 32'hCAFE_BABE},
    {1'b0, 4'h6, 4'h3, 32'hDEAD_BEEF},
    {1'b0, 4'h0, 4'h1, 32'hFFFF_FFFF},
    {1'b0, 4'h8, 4'h0, 32'h9900_0000},
    {1'b1, 4'h0, 4'h0, 32'h9922_3344},
    {1'b1, 4'h0, 4'h1, 32'hA5A5_A5A5},
    {1'b1, 4'h0, 4'h2, 32'h0000_00BE},
    {1'b1, 4'h0, 4'h3, 32'h00AD_BE00},
    {1'b0, 4'hF, 4'h4, 32'h0F0F_0F0F},
    {1'b1, 4'h0, 4'h4, 32'h0F0F_0F0F}
  };

  logic done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int busy;
    logic [31:0] last_rd;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    cur_addr = '0; cur_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'b0, ready}, 1);
    chk("R1 strobes in reset", {28'b0, cs_n}, 32'hF);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 ready", {31'b0, ready}, 1);
    chk("R1 cs", {28'b0, cs_n}, 32'hF);
    chk("R1 we/oe/drv/vld", {28'b0, we_n, oe_n, dq_oe, rd_valid}, 32'hC);

    last_rd = '0;
    for (int v = 0; v < 12; v++) begin
      logic rd; logic [3:0] st; logic [3:0] a; logic [31:0] d;
      {rd, st, a, d} = VEC[v];
      run_req(rd, st, a, d, busy);
      chk("R2 busy cycles", busy, 6);
      chk("R3 address during strobe", m_addr_err, 0);
      chk("R9 no drive during read enable", m_clash, 0);
      if (!rd) begin
        chk("R4 write pulse cycles", m_we, 4);
        chk("R4 no output enable in write", m_oe, 0);
        chk(st == 0 ? "R6 no lane on zero strobe" : "R4 lanes selected", {28'b0, m_cs}, {28'b0, st});
        chk("R5 drive cycles", m_drv, 5);
        chk("R5 driven data", m_data_err, 0);
        chk("R8 no valid on write", m_vld, 0);
        chk("R8 read data held", rd_data, last_rd);
      end else begin
        chk("R7 read enable cycles", m_oe, 3);
        chk("R7 all lanes", {28'b0, m_cs}, 32'hF);
        chk("R7 no drive", m_drv, 0);
        chk("R8 one valid pulse", m_vld, 1);
        chk("R8 read data", rd_data, d);
        last_rd = d;
      end
    end
    chk("R6 word untouched", mem[1], 32'hA5A5_A5A5);

    // valid pulse timing: high exactly in the cycle after the read strobe closes
    @(negedge clk);
    req_valid = 1'b1; req_rd = 1'b1; req_addr = 20'h0; req_strb = 4'h0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 no valid during strobe", {31'b0, rd_valid}, 0);
    chk("R7 oe low last strobe cycle", {31'b0, oe_n}, 0);
    @(negedge clk);
    chk("R8 valid after strobe", {31'b0, rd_valid}, 1);
    chk("R9 oe released", {31'b0, oe_n}, 1);
    @(negedge clk);
    chk("R8 valid drops", {31'b0, rd_valid}, 0);
    chk("R9 still turning around", {31'b0, ready}, 0);
    @(negedge clk);
    chk("R9 ready after turnaround", {31'b0, ready}, 1);

    // reset in the middle of a write strobe
    @(negedge clk);
    req_valid = 1'b1; req_rd = 1'b0; req_strb = 4'hF; req_addr = 20'h7;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 strobe active before reset", {31'b0, we_n}, 0);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset strobes", {26'b0, cs_n, we_n, oe_n}, 32'h3F);
    chk("R1 async reset drive/ready", {30'b0, dq_oe, ready}, 1);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule